// File: doc/BRIEF.md
# Split Issue / Read-Operands Queue

This block splits instruction decode into two steps. At the issue step an incoming instruction names its functional-unit class, a destination register and two source registers. Issue is refused (stalled) when the unit class it needs is busy, when its destination already has a pending writer, or when the wait buffer is full. An accepted instruction marks its destination as pending and enters a small wait buffer.

At the read-operands step every buffered instruction is examined each cycle. An entry is ready once none of its sources has a pending writer. The oldest ready entry is dispatched to execution and leaves the buffer. Because any ready entry may leave, an independent younger instruction overtakes an older one that is still waiting on a long-latency result. A writeback port names a register whose result has completed, which clears that register's pending mark. Writebacks may arrive in any order.

Top module: `issue_rdop_queue`

## Requirements
- R1: An issue request whose class bit in `unit_busy` is 1 is stalled (`iss_stall`=1, combinational in the same cycle) and does not enter the buffer.
- R2: An accepted instruction (`iss_valid`=1, `iss_stall`=0) whose sources have no pending writer appears on the dispatch port in the next cycle with `dsp_valid`=1 and its class, destination and sources unchanged.
- R3: An entry with a source whose pending mark is set does not dispatch; a writeback of that register clears the mark at the clock edge, and the entry dispatches in the following cycle.
- R4: A younger ready entry is dispatched while an older entry is still waiting on its sources.
- R5: When several entries are ready in the same cycle, the oldest (earliest issued) dispatches first, one entry per cycle.
- R6: Issue stalls while the destination register has a pending writer, and is accepted again once that register has been written back.
- R7: The buffer holds 4 entries (parameter `NENT`); with all entries occupied issue stalls, and a stalled request leaves the buffer unchanged.
- R8: A source equal to the entry's own destination does not make the entry wait on its own pending mark.
- R9: Reset empties the buffer and clears every pending mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_cls | input | CW | Functional-unit class of the request |
| iss_dst | input | RW | Destination register |
| iss_src1 | input | RW | First source register |
| iss_src2 | input | RW | Second source register |
| iss_stall | output | 1 | Request refused this cycle |
| unit_busy | input | NCLS | One busy bit per unit class |
| wb_valid | input | 1 | Writeback present |
| wb_reg | input | RW | Register written back |
| dsp_valid | output | 1 | An entry is dispatched this cycle |
| dsp_cls | output | CW | Class of the dispatched entry |
| dsp_dst | output | RW | Destination of the dispatched entry |
| dsp_src1 | output | RW | First source of the dispatched entry |
| dsp_src2 | output | RW | Second source of the dispatched entry |

## Verification
The bench builds the block with 8 registers, 4 unit classes and the default 4-entry buffer, so a handful of instructions fills the buffer and a single outstanding long-latency writer can hold every entry back at once. With that size the full-buffer stall, the oldest-first pick among several simultaneously released entries, and younger entries overtaking a blocked older one all arise within a few cycles of directed stimulus. Unit-busy and destination-pending stalls are exercised alongside, and each scenario confirms through the dispatch port that a refused request never entered the buffer.

// File: rtl/issue_rdop_queue.sv
module issue_rdop_queue #(
  parameter int NREG = 32,
  parameter int NCLS = 4,
  parameter int NENT = 4,
  localparam int RW = $clog2(NREG),
  localparam int CW = $clog2(NCLS),
  localparam int EW = $clog2(NENT),
  localparam int QW = $clog2(NENT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [CW-1:0] iss_cls,
  input  logic [RW-1:0] iss_dst,
  input  logic [RW-1:0] iss_src1,
  input  logic [RW-1:0] iss_src2,
  output logic          iss_stall,
  input  logic [NCLS-1:0] unit_busy,
  input  logic          wb_valid,
  input  logic [RW-1:0] wb_reg,
  output logic          dsp_valid,
  output logic [CW-1:0] dsp_cls,
  output logic [RW-1:0] dsp_dst,
  output logic [RW-1:0] dsp_src1,
  output logic [RW-1:0] dsp_src2
);

  logic [CW-1:0] e_cls [NENT];
  logic [RW-1:0] e_dst [NENT];
  logic [RW-1:0] e_s1  [NENT];
  logic [RW-1:0] e_s2  [NENT];
  logic [QW-1:0] cnt;
  logic [NREG-1:0] pend;
  logic [NENT-1:0] rdy;
  logic [EW-1:0] sel;
  logic [EW-1:0] wpos;
  logic acc;

  always_comb begin
    for (int i = 0; i < NENT; i++)
      rdy[i] = (QW'(i) < cnt)
             && (!pend[e_s1[i]] || e_s1[i] == e_dst[i])
             && (!pend[e_s2[i]] || e_s2[i] == e_dst[i]);
  end

  always_comb begin
    sel = '0;
    for (int i = NENT - 1; i >= 0; i--)
      if (rdy[i]) sel = EW'(i);
  end

  assign dsp_valid = |rdy;
  assign dsp_cls   = e_cls[sel];
  assign dsp_dst   = e_dst[sel];
  assign dsp_src1  = e_s1[sel];
  assign dsp_src2  = e_s2[sel];

  assign iss_stall = iss_valid && (unit_busy[iss_cls] || cnt == QW'(NENT) || pend[iss_dst]);
  assign acc       = iss_valid && !iss_stall;
  assign wpos      = EW'(cnt - QW'(dsp_valid));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= '0;
      for (int i = 0; i < NENT; i++) begin
        e_cls[i] <= '0;
        e_dst[i] <= '0;
        e_s1[i]  <= '0;
        e_s2[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NENT - 1; i++)
        if (dsp_valid && EW'(i) >= sel) begin
          e_cls[i] <= e_cls[i+1];
          e_dst[i] <= e_dst[i+1];
          e_s1[i]  <= e_s1[i+1];
          e_s2[i]  <= e_s2[i+1];
        end
      if (acc) begin
        e_cls[wpos] <= iss_cls;
        e_dst[wpos] <= iss_dst;
        e_s1[wpos]  <= iss_src1;
        e_s2[wpos]  <= iss_src2;
      end
      cnt <= cnt + QW'(acc) - QW'(dsp_valid);
      if (wb_valid) pend[wb_reg] <= 1'b0;
      if (acc) pend[iss_dst] <= 1'b1;
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= QW'(NENT));

  // R7
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && cnt == QW'(NENT)) |-> iss_stall);

  // R1
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && unit_busy[iss_cls]) |-> iss_stall);

  // R2
  issue_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !dsp_valid) |=> cnt == $past(cnt) + QW'(1));

  // R3
  dispatch_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !acc) |=> cnt == $past(cnt) - QW'(1));

  // R6
  issue_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> pend[$past(iss_dst)]);

  // R3
  wb_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(acc && iss_dst == wb_reg)) |=> !pend[$past(wb_reg)]);

endmodule

// File: tb/issue_rdop_queue_tb.sv
module issue_rdop_queue_tb;
  localparam int NREG = 8;
  localparam int NCLS = 4;
  localparam int RW = 3;
  localparam int CW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic iss_valid = 0;
  logic [CW-1:0] iss_cls = '0;
  logic [RW-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic iss_stall;
  logic [NCLS-1:0] unit_busy = '0;
  logic wb_valid = 0;
  logic [RW-1:0] wb_reg = '0;
  logic dsp_valid;
  logic [CW-1:0] dsp_cls;
  logic [RW-1:0] dsp_dst, dsp_src1, dsp_src2;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  issue_rdop_queue #(.NREG(NREG), .NCLS(NCLS), .NENT(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_dst(iss_dst),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_stall(iss_stall),
    .unit_busy(unit_busy), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .dsp_valid(dsp_valid), .dsp_cls(dsp_cls), .dsp_dst(dsp_dst),
    .dsp_src1(dsp_src1), .dsp_src2(dsp_src2)
  );

  always #5 clk = ~clk;

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, edge follows.
  task automatic cyc(input logic iv, input int c, input int d, input int s1, input int s2,
                     input logic wv, input int wr,
                     input logic es, input logic ev, input int ed, input string rq);
    @(negedge clk);
    iss_valid = iv; iss_cls = CW'(c); iss_dst = RW'(d);
    iss_src1 = RW'(s1); iss_src2 = RW'(s2);
    wb_valid = wv; wb_reg = RW'(wr);
    #1;
    if (iv) chk({rq, " stall"}, int'(iss_stall), int'(es));
    chk({rq, " dsp_valid"}, int'(dsp_valid), int'(ev));
    if (ev && dsp_valid) chk({rq, " dsp_dst"}, int'(dsp_dst), ed);
  endtask

  task automatic idle(input logic ev, input int ed, input string rq);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, ev, ed, rq);
  endtask

  task automatic wb(input int r, input logic ev, input int ed, input string rq);
    cyc(0, 0, 0, 0, 0, 1, r, 0, ev, ed, rq);
  endtask

  task automatic iss(input int c, input int d, input int s1, input int s2,
                     input logic es, input logic ev, input int ed, input string rq);
    cyc(1, c, d, s1, s2, 0, 0, es, ev, ed, rq);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; iss_valid = 0; wb_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_basic();
    idle(0, 0, "R9 reset empty");
    iss(1, 1, 2, 3, 0, 0, 0, "R2 issue");
    idle(1, 1, "R2 dispatch");
    chk("R2 dsp_cls", int'(dsp_cls), 1);
    chk("R2 dsp_src1", int'(dsp_src1), 2);
    chk("R2 dsp_src2", int'(dsp_src2), 3);
    idle(0, 0, "R2 drained");
    wb(1, 0, 0, "R2 wb");
  endtask

  task automatic t_overtake();
    iss(3, 1, 2, 3, 0, 0, 0, "R4 long op");
    iss(0, 4, 1, 2, 0, 1, 1, "R4 dependent");
    iss(1, 7, 5, 6, 0, 0, 0, "R3 dependent waits");
    idle(1, 7, "R4 independent overtakes");
    wb(1, 0, 0, "R3 still waiting");
    idle(1, 4, "R3 released after wb");
    wb(4, 0, 0, "R3 cleanup");
    wb(7, 0, 0, "R3 cleanup");
  endtask

  task automatic t_oldest_waw();
    iss(0, 1, 0, 0, 0, 0, 0, "R5 producer");
    iss(0, 3, 1, 2, 0, 1, 1, "R5 older");
    iss(0, 5, 1, 4, 0, 0, 0, "R5 younger");
    wb(1, 0, 0, "R5 both waiting");
    idle(1, 3, "R5 oldest first");
    idle(1, 5, "R5 then younger");
    iss(2, 3, 0, 0, 1, 0, 0, "R6 pending dst");
    wb(3, 0, 0, "R6 stalled request absent");
    iss(2, 3, 0, 0, 0, 0, 0, "R6 accepted after wb");
    idle(1, 3, "R6 dispatch");
    wb(3, 0, 0, "R6 cleanup");
    wb(5, 0, 0, "R6 cleanup");
  endtask

  task automatic t_busy();
    unit_busy = 4'b0100;
    iss(2, 2, 0, 0, 1, 0, 0, "R1 busy unit");
    iss(1, 2, 0, 0, 0, 0, 0, "R1 free unit");
    idle(1, 2, "R1 only free-unit request");
    chk("R1 dsp_cls", int'(dsp_cls), 1);
    unit_busy = '0;
    wb(2, 0, 0, "R1 cleanup");
  endtask

  task automatic t_full();
    iss(0, 1, 0, 0, 0, 0, 0, "R7 producer");
    iss(0, 2, 1, 0, 0, 1, 1, "R7 fill");
    iss(0, 3, 1, 0, 0, 0, 0, "R7 fill");
    iss(0, 4, 1, 0, 0, 0, 0, "R7 fill");
    iss(0, 5, 1, 0, 0, 0, 0, "R7 fill");
    iss(0, 6, 0, 0, 1, 0, 0, "R7 full stall");
    wb(1, 0, 0, "R7 stalled request absent");
    idle(1, 2, "R7 drain");
    idle(1, 3, "R7 drain");
    idle(1, 4, "R7 drain");
    idle(1, 5, "R7 drain");
    idle(0, 0, "R7 empty");
    for (int r = 2; r <= 5; r++) wb(r, 0, 0, "R7 cleanup");
  endtask

  task automatic t_self();
    iss(0, 6, 6, 6, 0, 0, 0, "R8 self source");
    idle(1, 6, "R8 no self wait");
    wb(6, 0, 0, "R8 cleanup");
  endtask

  task automatic t_reset();
    iss(0, 1, 0, 0, 0, 0, 0, "R9 producer");
    iss(0, 2, 1, 0, 0, 1, 1, "R9 waiter");
    idle(0, 0, "R9 waiter held");
    do_reset();
    iss(0, 1, 0, 0, 0, 0, 0, "R9 pend cleared");
    idle(1, 1, "R9 buffer cleared");
    idle(0, 0, "R9 waiter gone");
    wb(1, 0, 0, "R9 cleanup");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_basic();
    t_overtake();
    t_oldest_waw();
    t_busy();
    t_full();
    t_self();
    t_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule